// File: doc/BRIEF.md
# Address Translation Front End

This block classifies every virtual address before any page-table lookup. It takes a 64-bit virtual address with the current translation mode bits (direct-addressing enable, paging enable), the privilege level, a 64/32-bit mode flag and four direct-map window configuration words. It returns one of four results:
- a direct physical address;
- a window-mapped physical address;
- a bad-address fault;
- a request to continue on the TLB path.

Access permissions come with the direct and window results.

Requests arrive on a valid/ready stream and results leave on a valid/ready stream through one register stage. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. A result stays on the outputs, unchanged, for as long as `res_valid` is high and `res_ready` is low. The mode bits, privilege and window words are sampled together with the address at acceptance.

Top module: `atf_front`

## Requirements
- R1: When direct-addressing is set and paging is clear, the result code is 0 (direct), `pa` is `va[47:0]`, and `perm` is 3'b111 (bit 0 read, bit 1 write, bit 2 execute), whatever the windows hold.
- R2: A window can only hit when its enable bit for the current privilege is set. The enable bit is bit 0 for privilege 0 (kernel) and bit 3 for privilege 3 (user). Privileges 1 and 2 never hit. The segment compare uses `cfg[63:60]` against `va[63:60]` in 64-bit mode, and `cfg[31:29]` against `va[31:29]` in 32-bit mode.
- R3: When several windows hit, the lowest-numbered one is used.
- R4: A window hit in 64-bit mode gives code 1 (window), `pa = va[47:0]` and `perm` 3'b111.
- R5: A window hit in 32-bit mode gives code 1 and `pa = {cfg[27:25], va[28:0]}`, zero-extended, with `perm` 3'b111.
- R6: With no direct mode and no window hit, if `va[63:48]` is neither all zeros nor all ones, the code is 3 (bad address), `pa` and `perm` are 0 and `tlb_req` is 0.
- R7: With no direct mode, no window hit and a canonical address, the code is 2 (TLB), `tlb_req` is 1, and `pa` and `perm` are 0. `tlb_req` is 0 for every other code.
- R8: `req_ready = !res_valid || res_ready`. An accepted request produces its result in the next cycle. A stalled result holds all of its outputs.
- R9: During and right after reset, `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| va | input | 64 | Virtual address |
| da_en | input | 1 | Direct-addressing mode bit |
| pg_en | input | 1 | Paging mode bit |
| priv | input | 2 | Privilege level (0 kernel, 3 user) |
| mode64 | input | 1 | 1 for 64-bit mode, 0 for 32-bit mode |
| win_cfg | input | 256 | Four window words; window i at bits [64*i+63:64*i] |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_code | output | 2 | 0 direct, 1 window, 2 TLB, 3 bad address |
| pa | output | 48 | Physical address |
| perm | output | 3 | {execute, write, read} |
| tlb_req | output | 1 | Forward to the TLB path |

## Verification
The hardest case to reach from the ports is two or more windows hitting the same address at once while a result is stalled. This needs overlapping segment fields, matching enable bits for the chosen privilege, and back-pressure, all in the same cycle. The directed stimulus sets up 32-bit windows that share a segment but carry different PSEG values, so the winning window is visible in `pa`. Randomized requests then draw their addresses from the configured segments while the consumer drops `res_ready` at random.

// File: rtl/atf_pkg.sv
package atf_pkg;
  typedef enum logic [1:0] {
    ATF_DIRECT  = 2'd0,
    ATF_WINDOW  = 2'd1,
    ATF_TLB     = 2'd2,
    ATF_BADADDR = 2'd3
  } atf_res_e;

  localparam logic [1:0] PRIV_KERNEL = 2'd0;
  localparam logic [1:0] PRIV_USER   = 2'd3;

  // enable bit positions inside a window word
  localparam int unsigned EN_KERNEL_BIT = 0;
  localparam int unsigned EN_USER_BIT   = 3;
  // low bit of the 32-bit physical segment field
  localparam int unsigned PSEG_LSB      = 25;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/atf_win_match.sv
module atf_win_match
  import atf_pkg::*;
#(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned PA_W   = 48,
  parameter int unsigned VIRT_W = 48,
  parameter int unsigned SEG64  = 60,
  parameter int unsigned SEG32  = 29,
  parameter int unsigned W32    = 32
) (
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] cfg,
  input  logic [1:0]      priv,
  input  logic            mode64,
  output logic            hit,
  output logic [PA_W-1:0] pa
);
  localparam int unsigned SEG64_W = VA_W - SEG64;
  localparam int unsigned SEG32_W = W32 - SEG32;

  logic            priv_en;
  logic            seg_eq64;
  logic            seg_eq32;
  logic [SEG32_W-1:0] pseg;
  logic [PA_W-1:0] pa64;
  logic [PA_W-1:0] pa32;

  always_comb begin
    case (priv)
      PRIV_KERNEL: priv_en = cfg[EN_KERNEL_BIT];
      PRIV_USER:   priv_en = cfg[EN_USER_BIT];
      default:     priv_en = 1'b0;
    endcase
  end

  assign seg_eq64 = (va[SEG64 +: SEG64_W] == cfg[SEG64 +: SEG64_W]);
  assign seg_eq32 = (va[SEG32 +: SEG32_W] == cfg[SEG32 +: SEG32_W]);
  assign pseg     = cfg[PSEG_LSB +: SEG32_W];

  assign pa64 = PA_W'(va[VIRT_W-1:0]);
  assign pa32 = PA_W'({pseg, va[SEG32-1:0]});

  assign hit = priv_en && (mode64 ? seg_eq64 : seg_eq32);
  assign pa  = mode64 ? pa64 : pa32;

  // R2
  always_comb begin
    if (hit === 1'b1) begin
      priv_gate_chk: assert (priv == PRIV_KERNEL || priv == PRIV_USER);
    end
  end
endmodule

// File: rtl/atf_pick.sv
module atf_pick #(
  parameter int unsigned N    = 4,
  parameter int unsigned PA_W = 48
) (
  input  logic [N-1:0]      hits,
  input  logic [N*PA_W-1:0] pas,
  output logic              any_hit,
  output logic [PA_W-1:0]   pa_sel
);
  logic [N-1:0] grant;
  logic [N:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_prio
    assign grant[i]  = hits[i] && !seen[i];
    assign seen[i+1] = seen[i] || hits[i];
  end

  always_comb begin
    pa_sel = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) pa_sel = pas[i*PA_W +: PA_W];
    end
  end

  assign any_hit = seen[N];

  // R3
  always_comb begin
    if (!$isunknown(hits)) begin
      one_grant_chk: assert ($onehot0(grant) && (any_hit == (grant != '0)));
    end
  end
endmodule

// File: rtl/atf_canon.sv
module atf_canon #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned VIRT_W = 48,
  parameter int unsigned EXT_W  = 16
) (
  input  logic [VA_W-1:0] va,
  output logic            canonical
);
  logic [EXT_W-1:0] ext;
  assign ext       = va[VIRT_W +: EXT_W];
  assign canonical = (&ext) || !(|ext);
endmodule

// File: rtl/atf_front.sv
module atf_front
  import atf_pkg::*;
#(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned PA_W   = 48,
  parameter int unsigned VIRT_W = 48,
  parameter int unsigned EXT_W  = 16,
  parameter int unsigned NWIN   = 4,
  parameter int unsigned SEG64  = 60,
  parameter int unsigned SEG32  = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      va,
  input  logic                 da_en,
  input  logic                 pg_en,
  input  logic [1:0]           priv,
  input  logic                 mode64,
  input  logic [NWIN*VA_W-1:0] win_cfg,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [1:0]           res_code,
  output logic [PA_W-1:0]      pa,
  output logic [2:0]           perm,
  output logic                 tlb_req
);
  logic [NWIN-1:0]      win_hit;
  logic [NWIN*PA_W-1:0] win_pa;
  logic                 any_hit;
  logic [PA_W-1:0]      sel_pa;
  logic                 canonical;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    atf_win_match #(
      .VA_W(VA_W), .PA_W(PA_W), .VIRT_W(VIRT_W),
      .SEG64(SEG64), .SEG32(SEG32)
    ) u_win (
      .va    (va),
      .cfg   (win_cfg[w*VA_W +: VA_W]),
      .priv  (priv),
      .mode64(mode64),
      .hit   (win_hit[w]),
      .pa    (win_pa[w*PA_W +: PA_W])
    );
  end

  atf_pick #(.N(NWIN), .PA_W(PA_W)) u_pick (
    .hits   (win_hit),
    .pas    (win_pa),
    .any_hit(any_hit),
    .pa_sel (sel_pa)
  );

  atf_canon #(.VA_W(VA_W), .VIRT_W(VIRT_W), .EXT_W(EXT_W)) u_canon (
    .va       (va),
    .canonical(canonical)
  );

  atf_res_e        code_d;
  logic [PA_W-1:0] pa_d;
  logic [2:0]      perm_d;

  always_comb begin
    code_d = ATF_TLB;
    pa_d   = '0;
    perm_d = PERM_NONE;
    if (da_en && !pg_en) begin
      code_d = ATF_DIRECT;
      pa_d   = va[PA_W-1:0];
      perm_d = PERM_ALL;
    end else if (any_hit) begin
      code_d = ATF_WINDOW;
      pa_d   = sel_pa;
      perm_d = PERM_ALL;
    end else if (!canonical) begin
      code_d = ATF_BADADDR;
    end
  end

  logic take;
  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= ATF_DIRECT;
      pa        <= '0;
      perm      <= PERM_NONE;
      tlb_req   <= 1'b0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_code  <= code_d;
      pa        <= pa_d;
      perm      <= perm_d;
      tlb_req   <= (code_d == ATF_TLB);
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(pa) && $stable(res_code)
                               && $stable(perm) && $stable(tlb_req));
  // R8
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);
  // R7
  tlb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && tlb_req |-> res_code == ATF_TLB && perm == PERM_NONE && pa == '0);
  // R6
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code == ATF_BADADDR |-> pa == '0 && perm == PERM_NONE && !tlb_req);
endmodule

// File: tb/atf_front_bench.sv
`timescale 1ns/1ps
module atf_front_bench;
  localparam int NWIN = 4;

  typedef struct {
    logic [1:0]  code;
    logic [47:0] pa;
    logic [2:0]  perm;
    logic        tlb;
    string       tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [63:0] va = '0;
  logic da_en = 0, pg_en = 1, mode64 = 1;
  logic [1:0] priv = 0;
  logic [NWIN*64-1:0] win_cfg = '0;
  logic res_valid;
  logic res_ready = 1;
  logic [1:0] res_code;
  logic [47:0] pa;
  logic [2:0] perm;
  logic tlb_req;

  int tests = 0;
  int fails = 0;
  bit stall_en = 0;
  bit done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  atf_front u_atf_front (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .va(va), .da_en(da_en), .pg_en(pg_en), .priv(priv), .mode64(mode64),
    .win_cfg(win_cfg), .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .pa(pa), .perm(perm), .tlb_req(tlb_req)
  );

  function automatic exp_t model(logic [63:0] a, logic d, logic p, logic [1:0] pv,
                                 logic m64, logic [NWIN*64-1:0] cfg);
    exp_t e;
    bit found = 0;
    e.code = 2'd2; e.pa = '0; e.perm = 3'b000; e.tlb = 0; e.tag = "R7";
    if (d && !p) begin
      e.code = 2'd0; e.pa = a[47:0]; e.perm = 3'b111; e.tag = "R1";
      return e;
    end
    for (int w = 0; w < NWIN; w++) begin
      logic [63:0] c = cfg[w*64 +: 64];
      bit en = (pv == 2'd0) ? c[0] : (pv == 2'd3) ? c[3] : 1'b0;
      bit seq = m64 ? (a[63:60] == c[63:60]) : (a[31:29] == c[31:29]);
      if (!found && en && seq) begin
        found = 1;
        e.code = 2'd1; e.perm = 3'b111;
        if (m64) begin e.pa = a[47:0]; e.tag = "R4"; end
        else begin e.pa = {16'h0, c[27:25], a[28:0]}; e.tag = "R5"; end
      end
    end
    if (found) return e;
    if (!(a[63:48] == 16'h0 || a[63:48] == 16'hFFFF)) begin
      e.code = 2'd3; e.tag = "R6";
    end else e.tlb = 1;
    return e;
  endfunction

  task automatic send(logic [63:0] a, logic d, logic p, logic [1:0] pv,
                      logic m64, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1; va = a; da_en = d; pg_en = p; priv = pv; mode64 = m64;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    e = model(a, d, p, pv, m64, win_cfg);
    if (tag != "") e.tag = {tag, "/", e.tag};
    q.push_back(e);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  // monitor / scoreboard
  logic        prev_stall = 0;
  logic [47:0] prev_pa;
  logic [1:0]  prev_code;
  initial begin
    forever begin
      @(negedge clk);
      res_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          tests++;
          if (!(res_valid && pa == prev_pa && res_code == prev_code)) begin
            fails++;
            $display("FAIL R8 hold: valid=%0b pa=%h code=%0d exp valid=1 pa=%h code=%0d",
                     res_valid, pa, res_code, prev_pa, prev_code);
          end
        end
        prev_stall = res_valid && !res_ready;
        prev_pa = pa; prev_code = res_code;
        if (res_valid && res_ready) begin
          exp_t e;
          tests++;
          if (q.size() == 0) begin
            fails++;
            $display("FAIL R8 unexpected result code=%0d exp none", res_code);
          end else begin
            e = q.pop_front();
            if (res_code !== e.code || pa !== e.pa || perm !== e.perm || tlb_req !== e.tlb) begin
              fails++;
              $display("FAIL %s: code=%0d pa=%h perm=%b tlb=%b exp code=%0d pa=%h perm=%b tlb=%b",
                       e.tag, res_code, pa, perm, tlb_req, e.code, e.pa, e.perm, e.tlb);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    tests++;
    if (res_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R9: res_valid=%b req_ready=%b exp 0 1", res_valid, req_ready);
    end
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (res_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R9 after release: res_valid=%b req_ready=%b exp 0 1", res_valid, req_ready);
    end

    // windows: 0 = seg 9 kernel, 1 = seg 8 user, 2 = seg 9 user+kernel (shadowed), 3 = none
    win_cfg[0*64 +: 64] = 64'h9000_0000_0000_0001;
    win_cfg[1*64 +: 64] = 64'h8000_0000_0000_0008;
    win_cfg[2*64 +: 64] = 64'h9000_0000_0000_0009;
    win_cfg[3*64 +: 64] = 64'h0000_0000_0000_0000;

    // R1 direct mode, high bits masked, windows ignored
    send(64'h9123_4567_89AB_CDEF, 1, 0, 0, 1, "R1");
    send(64'hFFFF_0000_0000_1000, 1, 0, 3, 0, "R1");
    // R4 kernel hit on window 0
    send(64'h9000_1234_5678_9ABC, 0, 1, 0, 1, "R4");
    // R2 user hits window 1, kernel does not
    send(64'h8000_0000_0000_4000, 0, 1, 3, 1, "R2");
    send(64'h8000_0000_0000_4000, 0, 1, 0, 1, "R2");
    // R2 privilege 1 never hits
    send(64'h9000_0000_0000_0040, 0, 1, 1, 1, "R2");
    // R3 user on seg 9: window 0 has no user enable, window 2 wins
    send(64'h9000_0000_0000_0080, 0, 1, 3, 1, "R3");
    // both mode bits set still goes through windows
    send(64'h9000_0000_0000_0100, 1, 1, 0, 1, "R4");
    // R6 bad address, R7 canonical forwards
    send(64'h0001_0000_0000_0000, 0, 1, 0, 1, "R6");
    send(64'hFFFF_8000_0000_0000, 0, 1, 0, 1, "R7");
    send(64'h0000_7FFF_FFFF_F000, 0, 1, 3, 1, "R7");

    // 32-bit windows: 0 and 1 share seg 3'b101 with psegs 1 and 6
    win_cfg[0*64 +: 64] = 64'h0000_0000_A200_0001;
    win_cfg[1*64 +: 64] = 64'h0000_0000_AC00_0009;
    win_cfg[2*64 +: 64] = 64'h0000_0000_2E00_0008;
    win_cfg[3*64 +: 64] = 64'h0000_0000_0000_0000;
    send(64'h0000_0000_B234_5678, 0, 1, 0, 0, "R3");
    send(64'h0000_0000_B234_5678, 0, 1, 3, 0, "R5");
    send(64'h0000_0000_3FFF_FFFF, 0, 1, 3, 0, "R5");
    send(64'h0000_0000_3FFF_FFFF, 0, 1, 2, 0, "R2");
    send(64'h1234_0000_5000_0000, 0, 1, 0, 0, "R6");

    // random traffic with back-pressure
    stall_en = 1;
    win_cfg[3*64 +: 64] = 64'hF000_0000_6000_0009;
    for (int n = 0; n < 200; n++) begin
      logic [63:0] a;
      int sel = $urandom_range(0, 5);
      a = {$urandom, $urandom};
      case (sel)
        0: a[63:60] = 4'hF;
        1: a[63:48] = 16'h0;
        2: a[63:48] = 16'hFFFF;
        3: a[31:29] = 3'b101;
        default: ;
      endcase
      send(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R8");
    end
    stall_en = 0;
    repeat (20) @(negedge clk);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R8 drain: %0d results missing, exp 0", q.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule